// File: doc/BRIEF.md
# Nonvolatile SRAM power-fail sequencer

This block is a synchronous controller for the power-related operating modes of a battery-free nonvolatile SRAM. Two digitized supply-monitor flags come in: one is high while the supply is under the switch threshold (somewhere between 4.0 V and 4.5 V). The other is high while the supply is under the reset threshold (3.6 V). From these flags the block decides three things: when stores are blocked, when a timed recall copies nonvolatile data back into the SRAM, and when normal SRAM access is allowed.

A 1 µs tick enable drives a shared timer. A recall lasts `RECALL_TICKS` ticks (550 by default) and a store lasts `STORE_TICKS` ticks (10000 by default).

How far the supply fell decides what happens on recovery:
- A shallow brown-out, which never reaches the reset threshold, only blocks stores while it lasts. Access then resumes without a recall.
- A deep one arms a recall, which runs once the supply is back above the switch threshold.
- After reset the block assumes a cold start, so the first recovery always recalls.

Store requests are accepted only in the ready mode with a good supply. Any other request is dropped and answered by a one-cycle reject pulse.

Top module: `nvs_pwr_seq`

## Requirements
- R1: After reset release, the block sits in the supply-low mode with a recall armed: `store_inhibit_o`=1, `access_ready_o`=0, `recall_busy_o`=0, `store_busy_o`=0, `store_reject_o`=0, `standby_ok_o`=1.
- R2: In the cycle after `below_switch_i` is sampled high, `store_inhibit_o`=1 and `access_ready_o`=0, and they stay so while the flag stays high.
- R3: The first time `below_switch_i` is sampled low after reset, `recall_busy_o` rises in the following cycle.
- R4: If the supply dipped below the switch threshold with no recall armed and `below_reset_i` never sampled high, then `access_ready_o` rises in the cycle after `below_switch_i` returns low, and `recall_busy_o` stays 0.
- R5: Any cycle with `below_reset_i` sampled high arms a recall. That recall starts in the cycle after `below_switch_i` next returns low.
- R6: A recall ends on the clock edge at which the timer sees its `RECALL_TICKS`-th tick. Ticks that arrive on the edge where the recall starts are not counted. `access_ready_o` is 1 from the next cycle.
- R7: A `store_req_i` sampled while `access_ready_o`=1 and `below_switch_i`=0 starts a store. `store_busy_o` is 1 from the next cycle until the `STORE_TICKS`-th tick edge, and `access_ready_o` is 0 throughout.
- R8: Any other `store_req_i` changes no mode and gives `store_reject_o`=1 for exactly the next cycle.
- R9: If `below_switch_i` is sampled high during a recall, the recall is abandoned (`recall_busy_o`=0 next cycle) and a new one is armed for the next recovery.
- R10: `standby_ok_o` is 0 in every cycle in which a recall or a store is in progress, and 1 otherwise.
- R11: If `below_switch_i` is sampled high during a store, the store is cancelled (`store_busy_o`=0 next cycle) and the block enters the supply-low mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | 1 µs timer enable |
| below_switch_i | input | 1 | Supply is under the switch threshold |
| below_reset_i | input | 1 | Supply is under the reset threshold |
| store_req_i | input | 1 | Request a store cycle |
| recall_busy_o | output | 1 | Recall in progress |
| store_busy_o | output | 1 | Store in progress |
| store_inhibit_o | output | 1 | Stores blocked because the supply is low |
| access_ready_o | output | 1 | SRAM access allowed |
| standby_ok_o | output | 1 | No nonvolatile cycle in progress |
| store_reject_o | output | 1 | One-cycle pulse for an ignored store request |

## Verification
The assertions check these properties on every cycle:
- A low supply forces the inhibit and drops access one cycle later.
- An accepted store request starts a store, and an ignored one pulses reject.
- A supply drop in the middle of a recall re-arms a recall.
- Recall and store are never active together.
- The timer never passes its terminal count.

Only the bench's scenarios can show the history-dependent behaviour. That covers the recall decision between a shallow and a deep dip, the cold-start recall, and the exact tick-counted lengths of recall and store. The bench's cycle-by-cycle reference model checks each of these.

// File: rtl/nvs_pwr_pkg.sv
package nvs_pwr_pkg;

  typedef enum logic [1:0] {
    PS_DOWN   = 2'd0,
    PS_RECALL = 2'd1,
    PS_READY  = 2'd2,
    PS_STORE  = 2'd3
  } pwr_state_e;

  function automatic int unsigned cnt_width(input int unsigned a, input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return $clog2(m + 1);
  endfunction

endpackage

// File: rtl/nvs_rst_sync.sv
module nvs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) sync_q[i] <= 1'b0;
        else          sync_q[i] <= 1'b1;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) sync_q[i] <= 1'b0;
        else          sync_q[i] <= sync_q[i-1];
      end
    end
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/nvs_nv_timer.sv
module nvs_nv_timer #(
  parameter int unsigned CW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [CW-1:0] limit_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] last_val;

  assign last_val = limit_i - {{(CW-1){1'b0}}, 1'b1};
  assign done_o   = run_i && tick_i && (cnt_q == last_val);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)      cnt_d = '0;
    else if (tick_i) cnt_d = done_o ? '0 : cnt_q + {{(CW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R6: the tick count never reaches the terminal value while running
  a_r6_cnt_below_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < limit_i));

  // R6: an idle timer restarts from zero
  a_r6_idle_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/nvs_mode_fsm.sv
module nvs_mode_fsm
  import nvs_pwr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       below_switch_i,
  input  logic       below_reset_i,
  input  logic       store_req_i,
  input  logic       timer_done_i,
  output pwr_state_e state_o,
  output logic       reject_o
);
  pwr_state_e state_q, state_d;
  logic       armed_q, armed_d;
  logic       reject_q, reject_d;
  logic       accept;

  assign accept = (state_q == PS_READY) && !below_switch_i && store_req_i;

  always_comb begin
    state_d  = state_q;
    armed_d  = armed_q || below_reset_i;
    reject_d = store_req_i && !accept;
    if (below_switch_i) begin
      if (state_q == PS_RECALL) armed_d = 1'b1;
      state_d = PS_DOWN;
    end else begin
      unique case (state_q)
        PS_DOWN: begin
          if (armed_q) begin
            state_d = PS_RECALL;
            armed_d = 1'b0;
          end else begin
            state_d = PS_READY;
          end
        end
        PS_RECALL: if (timer_done_i) state_d = PS_READY;
        PS_READY:  if (accept)       state_d = PS_STORE;
        PS_STORE:  if (timer_done_i) state_d = PS_READY;
        default:   state_d = PS_DOWN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= PS_DOWN;
      armed_q  <= 1'b1;
      reject_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      armed_q  <= armed_d;
      reject_q <= reject_d;
    end
  end

  assign state_o  = state_q;
  assign reject_o = reject_q;

  // R9: losing the supply during a recall leaves a recall armed
  a_r9_abort_rearms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_RECALL && below_switch_i) |=> (state_q == PS_DOWN && armed_q));

  // R5: a deep dip always leaves a recall armed
  a_r5_deep_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (below_reset_i && below_switch_i) |=> armed_q);

  // R4: recovery with nothing armed goes straight to ready
  a_r4_shallow_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_DOWN && !armed_q && !below_switch_i && !below_reset_i) |=> (state_q == PS_READY));
endmodule

// File: rtl/nvs_pwr_seq.sv
module nvs_pwr_seq
  import nvs_pwr_pkg::*;
#(
  parameter int unsigned RECALL_TICKS = 550,
  parameter int unsigned STORE_TICKS  = 10000,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic below_switch_i,
  input  logic below_reset_i,
  input  logic store_req_i,
  output logic recall_busy_o,
  output logic store_busy_o,
  output logic store_inhibit_o,
  output logic access_ready_o,
  output logic standby_ok_o,
  output logic store_reject_o
);
  localparam int unsigned CW = cnt_width(RECALL_TICKS, STORE_TICKS);
  localparam logic [CW-1:0] RECALL_LIM = CW'(RECALL_TICKS);
  localparam logic [CW-1:0] STORE_LIM  = CW'(STORE_TICKS);

  logic          rst_s_n;
  pwr_state_e    state;
  logic          timer_run, timer_done;
  logic [CW-1:0] timer_limit;

  nvs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_s_n)
  );

  assign timer_run   = (state == PS_RECALL) || (state == PS_STORE);
  assign timer_limit = (state == PS_STORE) ? STORE_LIM : RECALL_LIM;

  nvs_nv_timer #(.CW(CW)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_s_n),
    .run_i   (timer_run),
    .tick_i  (tick_i),
    .limit_i (timer_limit),
    .done_o  (timer_done)
  );

  nvs_mode_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_s_n),
    .below_switch_i (below_switch_i),
    .below_reset_i  (below_reset_i),
    .store_req_i    (store_req_i),
    .timer_done_i   (timer_done),
    .state_o        (state),
    .reject_o       (store_reject_o)
  );

  assign recall_busy_o   = (state == PS_RECALL);
  assign store_busy_o    = (state == PS_STORE);
  assign store_inhibit_o = (state == PS_DOWN);
  assign access_ready_o  = (state == PS_READY);
  assign standby_ok_o    = !timer_run;

  // R2: a low supply blocks stores and access on the next cycle
  a_r2_low_inhibits: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    below_switch_i |=> (store_inhibit_o && !access_ready_o));

  // R7: an accepted request starts a store
  a_r7_store_starts: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (access_ready_o && store_req_i && !below_switch_i) |=> (store_busy_o && !store_reject_o));

  // R8: a request outside the ready mode is rejected
  a_r8_reject_pulse: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (store_req_i && !access_ready_o) |=> store_reject_o);

  // R10: at most one nonvolatile cycle is active, and standby is never reported during one
  a_r10_one_cycle_kind: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    $onehot0({recall_busy_o, store_busy_o, store_inhibit_o, access_ready_o}) &&
    !(standby_ok_o && (recall_busy_o || store_busy_o)));

  // R11: losing the supply cancels a store
  a_r11_store_cancel: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (store_busy_o && below_switch_i) |=> (!store_busy_o && store_inhibit_o));
endmodule

// File: tb/nvs_pwr_seq_tb.sv
`timescale 1ns/1ps
module nvs_pwr_seq_tb_top;
  localparam int RT = 6;
  localparam int ST = 9;
  localparam int TDIV = 3;

  logic clk = 1'b0;
  logic rst_n, tick, bsw, brst, sreq;
  logic rbusy, sbusy, sinh, aready, sbyok, srej;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  nvs_pwr_seq #(.RECALL_TICKS(RT), .STORE_TICKS(ST)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .below_switch_i(bsw),
    .below_reset_i(brst), .store_req_i(sreq), .recall_busy_o(rbusy),
    .store_busy_o(sbusy), .store_inhibit_o(sinh), .access_ready_o(aready),
    .standby_ok_o(sbyok), .store_reject_o(srej));

  // reference model: 0 low supply, 1 recall, 2 ready, 3 store
  int m_mode, m_armed, m_ticks, m_rej, m_sync;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_armed = 1; m_ticks = 0; m_rej = 0; m_sync = 0;
    end else begin
      if (m_sync == 2) begin
        int nm, na, nt, ok;
        nm = m_mode; na = m_armed; nt = m_ticks;
        ok = (m_mode == 2) && !bsw && sreq;
        m_rej = (sreq && !ok) ? 1 : 0;
        if (brst) na = 1;
        if (bsw) begin
          if (m_mode == 1) na = 1;
          nm = 0; nt = 0;
        end else if (m_mode == 0) begin
          if (m_armed != 0) begin nm = 1; na = 0; end else nm = 2;
          nt = 0;
        end else if (m_mode == 1 || m_mode == 3) begin
          if (tick) begin
            nt = m_ticks + 1;
            if (nt == ((m_mode == 1) ? RT : ST)) begin nm = 2; nt = 0; end
          end
        end else if (ok) begin
          nm = 3; nt = 0;
        end
        m_mode = nm; m_armed = na; m_ticks = nt;
      end
      if (m_sync < 2) m_sync++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R3 recall_busy", rbusy, m_mode == 1);
      check("R7 store_busy", sbusy, m_mode == 3);
      check("R2 store_inhibit", sinh, m_mode == 0);
      check("R4 access_ready", aready, m_mode == 2);
      check("R10 standby_ok", sbyok, !(m_mode == 1 || m_mode == 3));
      check("R8 store_reject", srej, m_rej);
    end
  end

  // tick generator: one tick every TDIV cycles
  initial begin
    tick = 1'b0;
    forever begin
      repeat (TDIV - 1) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_req();
    sreq = 1'b1;
    @(negedge clk);
    sreq = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; bsw = 1'b1; brst = 1'b1; sreq = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    // R1 reset state
    check("R1 inhibit", sinh, 1);
    check("R1 ready", aready, 0);
    check("R1 recall", rbusy, 0);
    check("R1 store", sbusy, 0);
    check("R1 reject", srej, 0);
    check("R1 standby", sbyok, 1);
    brst = 1'b0;
    cyc(2);
    bsw = 1'b0;
    cyc(1);
    check("R3 cold recall", rbusy, 1);
    check("R10 no standby in recall", sbyok, 0);
    cyc(RT * TDIV + 2);
    check("R6 recall done", aready, 1);
    // R7 store
    pulse_req();
    check("R7 store start", sbusy, 1);
    check("R7 access off", aready, 0);
    cyc(2);
    pulse_req();
    check("R8 reject during store", srej, 1);
    check("R8 store unaffected", sbusy, 1);
    cyc(ST * TDIV + 2);
    check("R7 store done", aready, 1);
    // R4 shallow dip
    bsw = 1'b1;
    cyc(1);
    check("R2 inhibit", sinh, 1);
    pulse_req();
    check("R8 reject while low", srej, 1);
    cyc(3);
    bsw = 1'b0;
    cyc(1);
    check("R4 no recall", rbusy, 0);
    check("R4 ready", aready, 1);
    // R5 deep dip
    bsw = 1'b1; cyc(2); brst = 1'b1; cyc(3); brst = 1'b0; cyc(2); bsw = 1'b0;
    cyc(1);
    check("R5 recall after deep dip", rbusy, 1);
    // R9 abort during recall
    cyc(4);
    bsw = 1'b1;
    cyc(1);
    check("R9 recall aborted", rbusy, 0);
    cyc(2);
    bsw = 1'b0;
    cyc(1);
    check("R9 recall rearmed", rbusy, 1);
    cyc(RT * TDIV + 2);
    check("R6 ready after recall", aready, 1);
    // R11 store cancelled
    pulse_req();
    cyc(3);
    bsw = 1'b1;
    cyc(1);
    check("R11 store cancelled", sbusy, 0);
    check("R11 inhibit", sinh, 1);
    cyc(2);
    bsw = 1'b0;
    cyc(1);
    check("R11 back to ready", aready, 1);
    cyc(3);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: got 0 expected 1 (run completion)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule